// File: doc/BRIEF.md
# CPU Status Register with Flag/Write Arbitration

This block holds the 8-bit status register of a small processor core. It merges two sources of update into that register. The first source is the arithmetic flag logic, which drives the zero, digit-carry and carry values, each with its own update enable. The second source is an explicit register write issued by an instruction that names the status register as its destination. Four event strobes also act on the register: power-up, watchdog clear, sleep entry and watchdog timeout. These strobes maintain two read-only flags that record how the core last stopped or restarted.

Arithmetic flag updates always win over an explicit write. Whenever an instruction updates any arithmetic flag, it blocks its own write to all three arithmetic bits. The two event flags and the three top bits cannot be written at all. An explicit write can therefore leave a value in the register that differs from the data written. For example, clearing the register through a clear instruction, which also raises the zero flag, gives `000u u1uu`.

The register is updated on the rising clock edge. Its value appears on the readback port from the following cycle onward.

Top module: `cpu_stat_reg`

## Requirements
- R1: Bits 7 to 5 of the readback are always 0, whatever data is written.
- R2: After reset the readback is 8'h18: bit 4 (time-out) and bit 3 (power-down) are 1, and bits 2..0 are 0.
- R3: An explicit write in a cycle where no arithmetic update enable is high loads write data bit 2 into the zero flag (bit 2), bit 1 into digit carry (bit 1) and bit 0 into carry (bit 0).
- R4: An arithmetic flag whose update enable is high takes the matching ALU flag input on the next edge, whether or not a write occurs. Enable and flag vectors use bit 2 = zero, bit 1 = digit carry, bit 0 = carry.
- R5: If any arithmetic update enable is high in the same cycle as an explicit write, the write data has no effect on bits 2..0. Flags whose enable is low keep their value. A write of 0 with only the zero flag updated to 1 yields `000u u1uu`.
- R6: An explicit write never changes bit 4 or bit 3.
- R7: Bit 4 is cleared on a watchdog timeout. Without a timeout, it is set by power-up, watchdog clear or sleep entry. A timeout wins over every setting strobe in the same cycle.
- R8: Bit 3 is set by power-up or watchdog clear. It is cleared by sleep entry only when neither of those strobes is present in the same cycle.
- R9: In a cycle with no write, no update enable and no event strobe, every bit holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_flag_i | input | 3 | ALU flag values (bit 2 zero, bit 1 digit carry, bit 0 carry) |
| alu_upd_i | input | 3 | Per-flag update enables, same bit order |
| wr_en_i | input | 1 | Explicit register write strobe |
| wr_data_i | input | 8 | Explicit write data |
| pwrup_i | input | 1 | Power-up event strobe |
| wdt_clr_i | input | 1 | Watchdog clear event strobe |
| sleep_i | input | 1 | Sleep entry event strobe |
| wdt_to_i | input | 1 | Watchdog timeout event strobe |
| stat_o | output | 8 | Register readback |

## Verification
The assertions assume that all inputs are known and steady around the rising edge. They assume the arithmetic enables and the event strobes are single-cycle pulses sampled on that edge. Several strobes may legally be high together, so no assertion assumes mutual exclusion between them.

The bench drives every input from the falling edge. It sweeps all 2048 combinations of enables, flag values, write strobe and event strobes, and takes the write data from an arithmetic sequence. That sequence includes values with the top bits and the event-flag bit positions set. The sweep therefore covers both the conflicting-strobe cases and the ignored-bit cases.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int ARITH_W = 3;
    localparam int IDX_C   = 0;
    localparam int IDX_DC  = 1;
    localparam int IDX_Z   = 2;
    localparam int IDX_PD  = 3;
    localparam int IDX_TO  = 4;
    localparam int IMPL_W  = 5;

    typedef struct packed {
        logic               tmo;
        logic               pwd;
        logic [ARITH_W-1:0] ar;
    } stat_t;

    typedef struct packed {
        logic pwrup;
        logic wdt_clr;
        logic sleep;
        logic wdt_to;
    } evt_t;
endpackage

// File: rtl/stat_flag_merge.sv
module stat_flag_merge #(
    parameter int W = 3
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] upd_i,
    input  logic [W-1:0] alu_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_dat_i,
    output logic [W-1:0] nxt_o
);
    logic lock;

    // any flag update by the instruction blocks its own write to all arithmetic bits
    assign lock = |upd_i;

    for (genvar i = 0; i < W; i++) begin : g_flag
        always_comb begin
            if (upd_i[i]) begin
                nxt_o[i] = alu_i[i];
            end else if (wr_en_i && !lock) begin
                nxt_o[i] = wr_dat_i[i];
            end else begin
                nxt_o[i] = cur_i[i];
            end
        end
    end
endmodule

// File: rtl/stat_event_unit.sv
module stat_event_unit
    import stat_pkg::*;
(
    input  evt_t ev_i,
    input  logic tmo_i,
    input  logic pwd_i,
    output logic tmo_o,
    output logic pwd_o
);
    always_comb begin
        // time-out flag: timeout clears and wins
        if (ev_i.wdt_to) begin
            tmo_o = 1'b0;
        end else if (ev_i.pwrup || ev_i.wdt_clr || ev_i.sleep) begin
            tmo_o = 1'b1;
        end else begin
            tmo_o = tmo_i;
        end

        // power-down flag: set sources win over sleep
        if (ev_i.pwrup || ev_i.wdt_clr) begin
            pwd_o = 1'b1;
        end else if (ev_i.sleep) begin
            pwd_o = 1'b0;
        end else begin
            pwd_o = pwd_i;
        end
    end
endmodule

// File: rtl/cpu_stat_reg.sv
module cpu_stat_reg
    import stat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ARITH_W-1:0] alu_flag_i,
    input  logic [ARITH_W-1:0] alu_upd_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               pwrup_i,
    input  logic               wdt_clr_i,
    input  logic               sleep_i,
    input  logic               wdt_to_i,
    output logic [DATA_W-1:0]  stat_o
);
    localparam int HI_W = DATA_W - IMPL_W;
    localparam stat_t RST_VAL = '{tmo: 1'b1, pwd: 1'b1, ar: '0};

    stat_t              st_d, st_q;
    evt_t               ev;
    logic [ARITH_W-1:0] ar_nxt;
    logic               tmo_nxt, pwd_nxt;

    assign ev = '{pwrup: pwrup_i, wdt_clr: wdt_clr_i, sleep: sleep_i, wdt_to: wdt_to_i};

    stat_flag_merge #(.W(ARITH_W)) u_merge (
        .cur_i   (st_q.ar),
        .upd_i   (alu_upd_i),
        .alu_i   (alu_flag_i),
        .wr_en_i (wr_en_i),
        .wr_dat_i(wr_data_i[ARITH_W-1:0]),
        .nxt_o   (ar_nxt)
    );

    stat_event_unit u_evt (
        .ev_i (ev),
        .tmo_i(st_q.tmo),
        .pwd_i(st_q.pwd),
        .tmo_o(tmo_nxt),
        .pwd_o(pwd_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ar  = ar_nxt;
        st_d.tmo = tmo_nxt;
        st_d.pwd = pwd_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = {{HI_W{1'b0}}, st_q.tmo, st_q.pwd, st_q.ar};

    // R1: top bits stay clear even when written with ones
    a_r1_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (|wr_data_i[DATA_W-1:IMPL_W]) |=> stat_o[DATA_W-1:IMPL_W] == '0);

    // R4: updated flag follows the ALU value
    a_r4_alu_wins: assert property (@(posedge clk) disable iff (!rst_n)
        alu_upd_i[IDX_C] |=> stat_o[IDX_C] == $past(alu_flag_i[IDX_C]));

    // R5: non-updated digit carry ignores write while another flag updates
    a_r5_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (|alu_upd_i) && !alu_upd_i[IDX_DC] |=> stat_o[IDX_DC] == $past(stat_o[IDX_DC]));

    // R6: write alone never moves the event flags
    a_r6_evt_ro: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (wr_data_i[IDX_TO:IDX_PD] != stat_o[IDX_TO:IDX_PD]) &&
        !pwrup_i && !wdt_clr_i && !sleep_i && !wdt_to_i
        |=> stat_o[IDX_TO:IDX_PD] == $past(stat_o[IDX_TO:IDX_PD]));

    // R7: timeout clears time-out flag
    a_r7_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to_i |=> !stat_o[IDX_TO]);

    // R8: sleep without set source clears power-down flag
    a_r8_sleep_pd: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i && !pwrup_i && !wdt_clr_i |=> !stat_o[IDX_PD]);

    // R9: idle cycle holds the register
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i && (alu_upd_i == '0) && !pwrup_i && !wdt_clr_i && !sleep_i && !wdt_to_i
        |=> $stable(stat_o));
endmodule

// File: tb/cpu_stat_reg_bench.sv
module cpu_stat_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] alu_flag = '0, alu_upd = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pwrup = 1'b0, wdt_clr = 1'b0, sleep = 1'b0, wdt_to = 1'b0;
    logic [7:0] stat;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cyc = 0;

    logic [2:0] m_ar;
    logic       m_to, m_pd;

    always #5 clk = ~clk;

    cpu_stat_reg u_cpu_stat_reg (
        .clk(clk), .rst_n(rst_n),
        .alu_flag_i(alu_flag), .alu_upd_i(alu_upd),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .pwrup_i(pwrup), .wdt_clr_i(wdt_clr), .sleep_i(sleep), .wdt_to_i(wdt_to),
        .stat_o(stat)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    // model: next state from the requirements
    task automatic model_step();
        for (int i = 0; i < 3; i++) begin
            if (alu_upd[i]) m_ar[i] = alu_flag[i];
            else if (wr_en && alu_upd == 3'b000) m_ar[i] = wr_data[i];
        end
        if (wdt_to) m_to = 1'b0;
        else if (pwrup || wdt_clr || sleep) m_to = 1'b1;
        if (pwrup || wdt_clr) m_pd = 1'b1;
        else if (sleep) m_pd = 1'b0;
    endtask

    task automatic drive(input logic [2:0] fl, input logic [2:0] up, input logic we,
                         input logic [7:0] d, input logic [3:0] ev);
        alu_flag = fl; alu_upd = up; wr_en = we; wr_data = d;
        {pwrup, wdt_clr, sleep, wdt_to} = ev;
        model_step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        m_ar = 3'b000; m_to = 1'b1; m_pd = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 reset value", stat, 8'h18);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 after release", stat, 8'h18);

        // R3/R6/R1: write ones everywhere, no flag update
        drive(3'b000, 3'b000, 1'b1, 8'hE2, 4'b0000);
        chk("R3 R6 R1 plain write", stat, 8'h1A);

        // R5: clear instruction, only zero flag updated
        drive(3'b100, 3'b100, 1'b1, 8'h00, 4'b0000);
        chk("R5 clear gives 000u u1uu", stat, 8'h1E);

        // R9: idle hold
        drive(3'b000, 3'b000, 1'b0, 8'hFF, 4'b0000);
        chk("R9 idle hold", stat, 8'h1E);

        // R4: alu wins over write on carry
        drive(3'b001, 3'b001, 1'b1, 8'hFE, 4'b0000);
        chk("R4 alu over write", stat, 8'h1F);

        // R7: timeout with power-up: timeout wins for bit 4, bit 3 set
        drive(3'b000, 3'b000, 1'b0, 8'h00, 4'b1001);
        chk("R7 timeout wins", stat, 8'h0F);

        // R8: sleep clears power-down, sets time-out
        drive(3'b000, 3'b000, 1'b0, 8'h00, 4'b0010);
        chk("R8 sleep clears pd", stat, 8'h17);

        // exhaustive sweep over all strobe/enable/flag combinations
        for (int k = 0; k < 2048; k++) begin
            logic [10:0] v;
            logic [7:0]  d;
            v = k[10:0];
            d = 8'(k * 37 + 11);
            drive(v[2:0], v[5:3], v[6], d, v[10:7]);
            chk("R1 top bits", {stat[7:5], 5'b0}, 8'h00);
            chk("R3 R4 R5 R9 arith flags", {5'b0, stat[2:0]}, {5'b0, m_ar});
            chk("R6 R7 time-out bit", {7'b0, stat[4]}, {7'b0, m_to});
            chk("R6 R8 power-down bit", {7'b0, stat[3]}, {7'b0, m_pd});
        end

        finish_run();
    end
endmodule